// File: doc/BRIEF.md
# Cartridge ROM Page Mapper

This block decides, for every CPU memory cycle, whether a cartridge ROM page answers and which one. It holds three small pieces of state written from the I/O side: the upper-bank select byte, the two ROM-disable bits of the mode register, and a five-bit secondary mapping register. From these, the top two CPU address bits and the read and write strobes, it produces a 5-bit cartridge page number, a ROM chip select, a RAM write-through flag and a select for the memory-mapped register page.

The upper bank (C000h to FFFFh) translates a logical select byte onto cartridge pages. Small values land on a fixed default page, except the value that matches the disk code, which lands on the disk page. Values with the top bit set address a cartridge page directly. The low bank can sit at 0000h, 4000h or 8000h and shows one of the first eight cartridge pages. In its fourth placement it sits at 0000h and the register page appears at 4000h to 7FFFh. The secondary register can only be loaded while the feature lock is open; a locked write in its pattern acts as an ordinary mode-register write.

All pins are plain control and status: the block has no data stream and no handshake. Register writes take effect at the clock edge where their strobe is high; the four outputs follow the address, strobes and stored state combinationally.

Top module: `rom_page_mapper`

## Requirements
- R1: After reset the select byte, the secondary register and both disable bits are zero: a read at 0000h-3FFFh selects ROM with page 0, and a read or write at 4000h-7FFFh asserts neither reg_page_sel nor rom_cs.
- R2: With io_data bit 7 of the stored select byte clear and the byte not equal to the disk code, a C000h-FFFFh access reports page 1.
- R3: When the stored select byte equals the disk code (0 when disk_strap is 0, 7 when disk_strap is 1), a C000h-FFFFh access reports page 3.
- R4: When bit 7 of the stored select byte is set, a C000h-FFFFh access reports its bits 4:0 as the page.
- R5: A mode_wr with io_data[7:5] = 101 and lock_open high loads io_data[4:0] into the secondary register and leaves the disable bits unchanged; with lock_open low the same write leaves the secondary register unchanged and updates the disable bits as in R6.
- R6: A mode_wr with io_data[7:6] = 10 (and not loading the secondary register) stores io_data[2] as the low-bank disable and io_data[3] as the upper-bank disable; a mode_wr with io_data[7:6] other than 10 changes no state.
- R7: Secondary bits 4:3 place the low bank: 00 at 0000h, 01 at 4000h, 10 at 8000h, 11 at 0000h with the register page at 4000h-7FFFh.
- R8: Outside C000h-FFFFh, cart_page is {2'b00, secondary bits 2:0}.
- R9: ext_rom_dis high forces rom_cs and ram_wr_thru low in every bank.
- R10: A write into an enabled ROM bank asserts ram_wr_thru and not rom_cs; a read there asserts rom_cs and not ram_wr_thru.
- R11: With the register page on, any read or write at 4000h-7FFFh asserts reg_page_sel and neither rom_cs nor ram_wr_thru.
- R12: Accesses outside an enabled ROM bank and outside the register page assert none of rom_cs, ram_wr_thru and reg_page_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| io_data | input | 8 | I/O write data |
| upsel_wr | input | 1 | Write strobe of the upper-bank select port |
| mode_wr | input | 1 | Write strobe of the mode port |
| disk_strap | input | 1 | Disk code choice: 0 gives code 0, 1 gives code 7 |
| ext_rom_dis | input | 1 | External ROM disable |
| lock_open | input | 1 | Feature lock is open |
| cart_page | output | 5 | Cartridge page number |
| rom_cs | output | 1 | ROM chip select |
| ram_wr_thru | output | 1 | Write goes through to RAM under ROM |
| reg_page_sel | output | 1 | Register page selected |

## Verification
On every cycle the assertions check that a locked secondary-pattern write and a foreign mode-port write leave the mapping state untouched, that the register page never coincides with a ROM select or write-through, that the external disable always wins, that a chip select only accompanies a read, and that small select values only reach pages 1 or 3. Only the bench scenarios show the actual page numbers, the placement of the low bank for each secondary value and the interaction of both disable bits with each bank, which are swept over every select byte and every secondary value.

// File: rtl/rom_map_pkg.sv
package rom_map_pkg;
  // Placement of the low ROM bank (secondary register bits 4:3)
  typedef enum logic [1:0] {
    LB_AT_0000      = 2'b00,
    LB_AT_4000      = 2'b01,
    LB_AT_8000      = 2'b10,
    LB_AT_0000_REGS = 2'b11
  } low_place_e;

  typedef struct packed {
    logic [1:0] place;
    logic [2:0] page;
  } sec_map_t;

  localparam int unsigned REGION_W = 2;
  localparam logic [REGION_W-1:0] REGION_REGS = 2'd1;
  localparam logic [REGION_W-1:0] REGION_HIGH = 2'd3;
endpackage

// File: rtl/rom_map_regs.sv
module rom_map_regs
  import rom_map_pkg::*;
#(
  parameter int unsigned SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       io_data,
  input  logic             upsel_wr,
  input  logic             mode_wr,
  input  logic             lock_open,
  output logic [SEL_W-1:0] upsel_q,
  output sec_map_t         sec_q,
  output logic             low_dis_q,
  output logic             up_dis_q
);
  logic mode_pattern;
  logic sec_load;

  assign mode_pattern = (io_data[7:6] == 2'b10);
  assign sec_load     = mode_pattern && io_data[5] && lock_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upsel_q   <= '0;
      sec_q     <= '0;
      low_dis_q <= 1'b0;
      up_dis_q  <= 1'b0;
    end else begin
      if (upsel_wr) upsel_q <= io_data[SEL_W-1:0];
      if (mode_wr && sec_load) begin
        sec_q <= sec_map_t'(io_data[4:0]);
      end else if (mode_wr && mode_pattern) begin
        low_dis_q <= io_data[2];
        up_dis_q  <= io_data[3];
      end
    end
  end

  assert_locked_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && io_data[7:5] == 3'b101 && !lock_open) |=> $stable(sec_q));

  assert_open_sec_keeps_dis_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && io_data[7:5] == 3'b101 && lock_open) |=> ($stable(low_dis_q) && $stable(up_dis_q)));

  assert_foreign_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && io_data[7:6] != 2'b10 && !upsel_wr)
      |=> ($stable(sec_q) && $stable(low_dis_q) && $stable(up_dis_q) && $stable(upsel_q)));
endmodule

// File: rtl/rom_map_upper.sv
module rom_map_upper #(
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned PAGE_W      = 5,
  parameter int unsigned DISK_CODE_A = 0,
  parameter int unsigned DISK_CODE_B = 7,
  parameter int unsigned PAGE_DEFLT  = 1,
  parameter int unsigned PAGE_DISK   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              disk_strap,
  output logic [PAGE_W-1:0] page
);
  localparam logic [SEL_W-1:0]  CODE_A = SEL_W'(DISK_CODE_A);
  localparam logic [SEL_W-1:0]  CODE_B = SEL_W'(DISK_CODE_B);
  localparam logic [PAGE_W-1:0] PG_DEF = PAGE_W'(PAGE_DEFLT);
  localparam logic [PAGE_W-1:0] PG_DSK = PAGE_W'(PAGE_DISK);

  logic [SEL_W-1:0] disk_code;
  logic             direct;

  assign disk_code = disk_strap ? CODE_B : CODE_A;
  assign direct    = sel[SEL_W-1];

  always_comb begin
    if (direct)                 page = sel[PAGE_W-1:0];
    else if (sel == disk_code)  page = PG_DSK;
    else                        page = PG_DEF;
  end

  assert_small_sel_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel[SEL_W-1] |-> (page == PG_DEF || page == PG_DSK));
endmodule

// File: rtl/rom_map_decode.sv
module rom_map_decode
  import rom_map_pkg::*;
#(
  parameter int unsigned PAGE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REGION_W-1:0] region,
  input  logic                mem_rd,
  input  logic                mem_wr,
  input  logic                ext_rom_dis,
  input  logic                low_dis,
  input  logic                up_dis,
  input  sec_map_t            sec,
  input  logic [PAGE_W-1:0]   high_page,
  output logic [PAGE_W-1:0]   cart_page,
  output logic                rom_cs,
  output logic                ram_wr_thru,
  output logic                reg_page_sel
);
  localparam int unsigned LOW_PG_W = $bits(sec.page);

  logic [REGION_W-1:0] low_region;
  logic                regs_on, in_regs, in_low, in_high, rom_hit;

  always_comb begin
    unique case (low_place_e'(sec.place))
      LB_AT_4000: low_region = 2'd1;
      LB_AT_8000: low_region = 2'd2;
      default:    low_region = 2'd0;
    endcase
  end

  assign regs_on = (low_place_e'(sec.place) == LB_AT_0000_REGS);
  assign in_regs = regs_on && (region == REGION_REGS);
  assign in_low  = (region == low_region);
  assign in_high = (region == REGION_HIGH);
  assign rom_hit = !ext_rom_dis && !in_regs &&
                   ((in_low && !low_dis) || (in_high && !up_dis));

  assign cart_page    = in_high ? high_page : {{(PAGE_W-LOW_PG_W){1'b0}}, sec.page};
  assign rom_cs       = rom_hit && mem_rd;
  assign ram_wr_thru  = rom_hit && mem_wr;
  assign reg_page_sel = in_regs && (mem_rd || mem_wr);

  assert_regpage_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_page_sel |-> (!rom_cs && !ram_wr_thru));

  assert_ext_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rom_dis |-> (!rom_cs && !ram_wr_thru));

  assert_cs_needs_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> mem_rd);

  assert_thru_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr_thru |-> mem_wr);
endmodule

// File: rtl/rom_page_mapper.sv
module rom_page_mapper
  import rom_map_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned PAGE_W      = 5,
  parameter int unsigned DISK_CODE_A = 0,
  parameter int unsigned DISK_CODE_B = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [7:0]        io_data,
  input  logic              upsel_wr,
  input  logic              mode_wr,
  input  logic              disk_strap,
  input  logic              ext_rom_dis,
  input  logic              lock_open,
  output logic [PAGE_W-1:0] cart_page,
  output logic              rom_cs,
  output logic              ram_wr_thru,
  output logic              reg_page_sel
);
  logic [SEL_W-1:0]  upsel_q;
  sec_map_t          sec_q;
  logic              low_dis_q, up_dis_q;
  logic [PAGE_W-1:0] high_page;

  rom_map_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_data(io_data), .upsel_wr(upsel_wr),
    .mode_wr(mode_wr), .lock_open(lock_open), .upsel_q(upsel_q),
    .sec_q(sec_q), .low_dis_q(low_dis_q), .up_dis_q(up_dis_q)
  );

  rom_map_upper #(
    .SEL_W(SEL_W), .PAGE_W(PAGE_W),
    .DISK_CODE_A(DISK_CODE_A), .DISK_CODE_B(DISK_CODE_B)
  ) u_upper (
    .clk(clk), .rst_n(rst_n), .sel(upsel_q), .disk_strap(disk_strap),
    .page(high_page)
  );

  rom_map_decode #(.PAGE_W(PAGE_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .region(cpu_addr[ADDR_W-1 -: REGION_W]),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ext_rom_dis(ext_rom_dis),
    .low_dis(low_dis_q), .up_dis(up_dis_q), .sec(sec_q),
    .high_page(high_page), .cart_page(cart_page), .rom_cs(rom_cs),
    .ram_wr_thru(ram_wr_thru), .reg_page_sel(reg_page_sel)
  );
endmodule

// File: tb/rom_page_mapper_tb.sv
module rom_page_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic [7:0]  io_data = '0;
  logic        upsel_wr = 1'b0, mode_wr = 1'b0;
  logic        disk_strap = 1'b0, ext_rom_dis = 1'b0, lock_open = 1'b0;
  logic [4:0]  cart_page;
  logic        rom_cs, ram_wr_thru, reg_page_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench copy of the programmed state, kept from the requirements
  logic [7:0] m_upsel = '0;
  logic [4:0] m_sec = '0;
  logic       m_ldis = 0, m_udis = 0;

  always #10 clk = ~clk;

  rom_page_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_data(io_data), .upsel_wr(upsel_wr),
    .mode_wr(mode_wr), .disk_strap(disk_strap), .ext_rom_dis(ext_rom_dis),
    .lock_open(lock_open), .cart_page(cart_page), .rom_cs(rom_cs),
    .ram_wr_thru(ram_wr_thru), .reg_page_sel(reg_page_sel)
  );

  task automatic io_write(input logic is_mode, input logic [7:0] d);
    @(negedge clk);
    io_data = d;
    if (is_mode) mode_wr = 1'b1; else upsel_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0; upsel_wr = 1'b0;
  endtask

  task automatic check_access(input string tag, input logic [1:0] region,
                              input logic rd, input logic wr);
    logic [4:0] e_page;
    logic [1:0] low_reg;
    logic regs_on, in_regs, in_low, in_high, hit, e_cs, e_wt, e_rs;
    cpu_addr = {region, 14'h1A5};
    mem_rd = rd; mem_wr = wr;
    #2;
    regs_on = (m_sec[4:3] == 2'b11);
    low_reg = regs_on ? 2'd0 : m_sec[4:3];
    in_regs = regs_on && region == 2'd1;
    in_low  = region == low_reg;
    in_high = region == 2'd3;
    hit = !ext_rom_dis && !in_regs && ((in_low && !m_ldis) || (in_high && !m_udis));
    if (in_high)
      e_page = m_upsel[7] ? m_upsel[4:0] :
               (m_upsel == (disk_strap ? 8'd7 : 8'd0)) ? 5'd3 : 5'd1;
    else
      e_page = {2'b00, m_sec[2:0]};
    e_cs = hit && rd; e_wt = hit && wr; e_rs = in_regs && (rd || wr);
    checks++;
    if (cart_page !== e_page || rom_cs !== e_cs || ram_wr_thru !== e_wt ||
        reg_page_sel !== e_rs) begin
      fails++;
      $display("FAIL %s: region=%0d rd=%0b wr=%0b got page=%0d cs=%b wt=%b rs=%b exp page=%0d cs=%b wt=%b rs=%b",
               tag, region, rd, wr, cart_page, rom_cs, ram_wr_thru, reg_page_sel,
               e_page, e_cs, e_wt, e_rs);
    end
    @(negedge clk);
  endtask

  task automatic sweep_regions(input string tag);
    for (int r = 0; r < 4; r++) begin
      check_access(tag, 2'(r), 1'b1, 1'b0);
      check_access(tag, 2'(r), 1'b0, 1'b1);
      check_access(tag, 2'(r), 1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_access("R1", 2'd0, 1'b1, 1'b0);
    check_access("R1", 2'd1, 1'b1, 1'b0);
    check_access("R1", 2'd1, 1'b0, 1'b1);

    // R2 R3 R4: every select byte under both straps
    for (int s = 0; s < 2; s++) begin
      disk_strap = 1'(s);
      for (int v = 0; v < 256; v++) begin
        io_write(1'b0, 8'(v));
        m_upsel = 8'(v);
        check_access(v >= 128 ? "R4" : (v == (s ? 7 : 0) ? "R3" : "R2"),
                     2'd3, 1'b1, 1'b0);
      end
    end
    disk_strap = 1'b0;
    io_write(1'b0, 8'h92); m_upsel = 8'h92;

    // R5 R7 R8 R6 R9 R10 R11 R12: every secondary value with every disable pair
    lock_open = 1'b1;
    for (int sv = 0; sv < 32; sv++) begin
      for (int dv = 0; dv < 4; dv++) begin
        io_write(1'b1, {3'b100, 1'b0, 2'(dv), 2'b00});
        m_ldis = dv[0]; m_udis = dv[1];
        io_write(1'b1, {3'b101, 5'(sv)});
        m_sec = 5'(sv);
        ext_rom_dis = 1'b0;
        sweep_regions(sv[4:3] == 2'b11 ? "R11" : (dv == 0 ? "R7" : "R6"));
        ext_rom_dis = 1'b1;
        sweep_regions("R9");
        ext_rom_dis = 1'b0;
      end
    end
    sweep_regions("R10 R12 R8");

    // R5: locked write in the secondary pattern acts as a mode write
    io_write(1'b1, 8'hA1); m_sec = 5'h01;
    io_write(1'b1, 8'h80); m_ldis = 0; m_udis = 0;
    lock_open = 1'b0;
    io_write(1'b1, 8'hBC); m_ldis = 1; m_udis = 1;
    sweep_regions("R5");
    io_write(1'b1, 8'hA0); m_ldis = 0; m_udis = 0;
    sweep_regions("R5");

    // R6: writes outside the 10xxxxxx pattern change nothing
    lock_open = 1'b1;
    io_write(1'b1, 8'h0C);
    io_write(1'b1, 8'h5F);
    io_write(1'b1, 8'hFF);
    io_write(1'b1, 8'hC4);
    sweep_regions("R6");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule